// File: doc/BRIEF.md
# Parallel Host Port with Packet DMA

This block is the slave side of an asynchronous microprocessor bus. It holds six 8-bit write registers that the rest of the receiver uses for configuration. It returns status, block number and a stream of corrected packet bytes on reads. The bus signals (chip select, read strobe, write strobe, DMA acknowledge) are brought into the internal clock domain through two-flop synchronisers. All access, data and recovery timing is counted in internal clock cycles.

A 22-byte corrected packet is loaded by the decoder through a byte write port and released with a one-cycle pulse. Each read of address 0 returns the next byte, or the next byte pair when the bus-width strap is high, and advances an internal pointer. A DMA mode raises a request whenever unread bytes remain and the port is idle. In that mode the host reads address 0 with either the read strobe or the acknowledge pin, and the polarity of both the request and the acknowledge can be programmed. The ready output has two timing styles: it is either low during the access wait, or low during the data phase.

The controller has five states. IDLE goes to ACCESS on a read strobe, or to WR_HOLD on a write strobe, and that transition issues the register write. ACCESS counts its wait and then goes to DRIVE. DRIVE puts the data on the bus until the strobe is released, then goes to RECOVER. WR_HOLD goes to RECOVER when the write strobe is released. RECOVER counts the recovery gap and returns to IDLE.

Top module: `host_port_dma`

## Requirements
- R1: A write at address 1, 2, 3, 4, 5 or 6 stores din[7:0] on cfg_bic, cfg_bsync, cfg_fsync, cfg_ctl1, cfg_ctl2 or crc_byte respectively. A write at address 6 also raises crc_strobe for exactly one cycle.
- R2: A write at address 0 or at any address from 7 to 15 changes no cfg output and raises no crc_strobe.
- R3: A read at address 1 returns stat_in and a read at address 2 returns blkno_in, both zero-extended. A read at addresses 3 to 15 returns zero. A read at address 0 returns corrected packet data.
- R4: dout_oe_lo is high for every data phase. dout_oe_hi is high only when wide_bus is high and DMA mode is off; otherwise dout[15:8] reads as zero.
- R5: With cfg_ctl2 bit 3 clear, rdy is low for exactly ACC8 cycles after the strobe is recognised, and returns high when the data becomes valid.
- R6: With cfg_ctl2 bit 3 set, rdy stays high during the access wait, is low throughout the data phase, and is high again once the strobe is released.
- R7: Each address-0 read returns packet byte p in dout[7:0]. A wide read also returns byte p+1 in dout[15:8]. The read then advances p by 1 (narrow) or 2 (wide). Bytes at index 22 or above read as zero, and p saturates at 22. A pulse on pkt_release sets p to 0.
- R8: A wide address-0 read holds the access wait for ACC16 cycles instead of ACC8.
- R9: cfg_ctl2 bit 0 enables DMA mode. In DMA mode the request is active whenever the port is idle and unread bytes remain, and inactive during an access and after the last byte. The bus is forced to 8 bits.
- R10: With DMA on and cfg_ctl2 bit 1 set, the acknowledge pin (qualified by chip select) replaces rd_n, and rd_n is ignored. cfg_ctl2 bit 4 makes dreq active high, and bit 5 makes dack active high; both bits clear means both are active low.
- R11: After reset, rdy and dreq are high, both output enables are low, and every cfg output is zero.
- R12: After a data phase ends, no new access starts for REC cycles. A DMA data read instead holds DMA_REC cycles, and dreq becomes active again DMA_REC cycles after the data phase ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dack | input | 1 | DMA acknowledge, polarity set by cfg_ctl2 bit 5 |
| addr | input | 4 | Register address |
| wide_bus | input | 1 | Bus-width strap: 0 = 8 bits, 1 = 16 bits |
| din | input | 8 | Write data |
| dout | output | 16 | Read data |
| dout_oe_lo | output | 1 | Drive enable for dout[7:0] |
| dout_oe_hi | output | 1 | Drive enable for dout[15:8] |
| rdy | output | 1 | Read ready handshake |
| dreq | output | 1 | DMA request, polarity set by cfg_ctl2 bit 4 |
| stat_in | input | 8 | Status value returned at address 1 |
| blkno_in | input | 8 | Block number returned at address 2 |
| pkt_we | input | 1 | Packet byte write enable |
| pkt_widx | input | 5 | Packet byte index |
| pkt_wdata | input | 8 | Packet byte value |
| pkt_release | input | 1 | New packet released; clears the read pointer |
| cfg_bic | output | 8 | Allowed error count register |
| cfg_bsync | output | 8 | Block sync protection count register |
| cfg_fsync | output | 8 | Frame sync protection count register |
| cfg_ctl1 | output | 8 | First control register |
| cfg_ctl2 | output | 8 | Second control register (DMA, strobe, ready style, polarities) |
| crc_byte | output | 8 | Last byte written for checksum |
| crc_strobe | output | 1 | One-cycle pulse per checksum byte |

## Verification
Every cycle, the assertions check these properties: the high-byte enable appears only with the low enable, a wide strap and DMA off. Ignored writes leave all registers unchanged. The checksum strobe is a single-cycle pulse. The read pointer stays in range and clears on release. A data phase is followed by at least one idle cycle. An active request never overlaps a data phase. The ready level during a data phase matches the selected style. Only the bench scenarios can show the exact cycle counts of the access wait and the recovery gap, the ordering of bytes as the pointer walks to the packet end and saturates, the acknowledge pin taking over from the read strobe, and the polarity changes of the request and acknowledge pins.

// File: rtl/hp_pkg.sv
package hp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_DRIVE,
        ST_WR_HOLD,
        ST_RECOVER
    } hp_state_e;

    // write register addresses
    localparam logic [3:0] WA_BIC   = 4'h1;
    localparam logic [3:0] WA_BSYNC = 4'h2;
    localparam logic [3:0] WA_FSYNC = 4'h3;
    localparam logic [3:0] WA_CTL1  = 4'h4;
    localparam logic [3:0] WA_CTL2  = 4'h5;
    localparam logic [3:0] WA_CRC   = 4'h6;

    // read addresses
    localparam logic [3:0] RA_DATA  = 4'h0;
    localparam logic [3:0] RA_STAT  = 4'h1;
    localparam logic [3:0] RA_BLKNO = 4'h2;

    // control register 2 bit positions
    localparam int C2_DMA     = 0;
    localparam int C2_DACKRD  = 1;
    localparam int C2_RDYALT  = 3;
    localparam int C2_DREQINV = 4;
    localparam int C2_DACKINV = 5;

endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic s1_q, s2_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s1_q <= RST_VAL[i];
                    s2_q <= RST_VAL[i];
                end else begin
                    s1_q <= d[i];
                    s2_q <= s1_q;
                end
            end
            assign q[i] = s2_q;
        end
    endgenerate

endmodule

// File: rtl/hp_cfg_regs.sv
module hp_cfg_regs
    import hp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] bic_o,
    output logic [7:0] bsync_o,
    output logic [7:0] fsync_o,
    output logic [7:0] ctl1_o,
    output logic [7:0] ctl2_o,
    output logic [7:0] crc_byte_o,
    output logic       crc_strobe_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bic_o        <= '0;
            bsync_o      <= '0;
            fsync_o      <= '0;
            ctl1_o       <= '0;
            ctl2_o       <= '0;
            crc_byte_o   <= '0;
            crc_strobe_o <= 1'b0;
        end else begin
            crc_strobe_o <= 1'b0;
            if (wr_en) begin
                case (wr_addr)
                    WA_BIC:   bic_o   <= wr_data;
                    WA_BSYNC: bsync_o <= wr_data;
                    WA_FSYNC: fsync_o <= wr_data;
                    WA_CTL1:  ctl1_o  <= wr_data;
                    WA_CTL2:  ctl2_o  <= wr_data;
                    WA_CRC: begin
                        crc_byte_o   <= wr_data;
                        crc_strobe_o <= 1'b1;
                    end
                    default: ;  // prohibited addresses are dropped
                endcase
            end
        end
    end

    // R2
    bad_addr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == 4'h0 || wr_addr >= 4'h7)) |=>
        ($stable(bic_o) && $stable(bsync_o) && $stable(fsync_o) &&
         $stable(ctl1_o) && $stable(ctl2_o) && $stable(crc_byte_o) && !crc_strobe_o));

    // R1
    crc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_strobe_o |=> !crc_strobe_o);

endmodule

// File: rtl/hp_pkt_buf.sv
module hp_pkt_buf #(
    parameter int N  = 22,
    parameter int IW = $clog2(N),
    parameter int PW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [7:0]    wdata,
    input  logic          pkt_rel,
    input  logic          adv,
    input  logic          step2,
    output logic [7:0]    lo_byte,
    output logic [7:0]    hi_byte,
    output logic          avail
);

    logic [7:0]  mem_q [N];
    logic [PW-1:0] ptr_q;
    logic [PW:0]   ptr_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) mem_q[k] <= '0;
        end else if (we && int'(widx) < N) begin
            mem_q[widx] <= wdata;
        end
    end

    assign ptr_nxt = {1'b0, ptr_q} + (step2 ? (PW+1)'(2) : (PW+1)'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (pkt_rel) begin
            ptr_q <= '0;
        end else if (adv) begin
            ptr_q <= (int'(ptr_nxt) > N) ? PW'(N) : ptr_nxt[PW-1:0];
        end
    end

    always_comb begin
        lo_byte = '0;
        hi_byte = '0;
        for (int k = 0; k < N; k++) begin
            if (int'(ptr_q) == k)     lo_byte = mem_q[k];
            if (int'(ptr_q) + 1 == k) hi_byte = mem_q[k];
        end
    end

    assign avail = int'(ptr_q) < N;

    // R7
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr_q) <= N);

    // R7
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_rel |=> (ptr_q == '0));

endmodule

// File: rtl/host_port_dma.sv
module host_port_dma
    import hp_pkg::*;
#(
    parameter int PKT_BYTES = 22,
    parameter int ACC8      = 4,
    parameter int ACC16     = 8,
    parameter int REC       = 6,
    parameter int DMA_REC   = 16,
    parameter int IW        = $clog2(PKT_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          dack,
    input  logic [3:0]    addr,
    input  logic          wide_bus,
    input  logic [7:0]    din,
    output logic [15:0]   dout,
    output logic          dout_oe_lo,
    output logic          dout_oe_hi,
    output logic          rdy,
    output logic          dreq,
    input  logic [7:0]    stat_in,
    input  logic [7:0]    blkno_in,
    input  logic          pkt_we,
    input  logic [IW-1:0] pkt_widx,
    input  logic [7:0]    pkt_wdata,
    input  logic          pkt_release,
    output logic [7:0]    cfg_bic,
    output logic [7:0]    cfg_bsync,
    output logic [7:0]    cfg_fsync,
    output logic [7:0]    cfg_ctl1,
    output logic [7:0]    cfg_ctl2,
    output logic [7:0]    crc_byte,
    output logic          crc_strobe
);

    localparam int CMAX_A = (ACC8 > ACC16) ? ACC8 : ACC16;
    localparam int CMAX_B = (REC > DMA_REC) ? REC : DMA_REC;
    localparam int CMAX   = (CMAX_A > CMAX_B) ? CMAX_A : CMAX_B;
    localparam int CW     = $clog2(CMAX + 1);

    hp_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [3:0]    addr_q;
    logic          wide_q;
    logic [15:0]   rdata_q, rdata_d;
    logic          acc_start, drive_start, drive_end, wr_go;

    logic          cs_s, rd_s, wr_s, dack_s;
    logic [7:0]    ctl2_w;
    logic          dma_en, dack_act, rd_strobe, wr_strobe, use_wide;
    logic [7:0]    pk_lo, pk_hi;
    logic          pk_avail, dreq_act;

    hp_sync #(.W(4), .RST_VAL(4'hF)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, rd_n, wr_n, dack}),
        .q     ({cs_s, rd_s, wr_s, dack_s})
    );

    hp_cfg_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_go),
        .wr_addr      (addr),
        .wr_data      (din),
        .bic_o        (cfg_bic),
        .bsync_o      (cfg_bsync),
        .fsync_o      (cfg_fsync),
        .ctl1_o       (cfg_ctl1),
        .ctl2_o       (ctl2_w),
        .crc_byte_o   (crc_byte),
        .crc_strobe_o (crc_strobe)
    );

    assign cfg_ctl2 = ctl2_w;

    hp_pkt_buf #(.N(PKT_BYTES), .IW(IW)) u_pkt (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (pkt_we),
        .widx    (pkt_widx),
        .wdata   (pkt_wdata),
        .pkt_rel (pkt_release),
        .adv     (drive_end && addr_q == RA_DATA),
        .step2   (wide_q),
        .lo_byte (pk_lo),
        .hi_byte (pk_hi),
        .avail   (pk_avail)
    );

    // strobe decoding
    assign dma_en    = ctl2_w[C2_DMA];
    assign dack_act  = ctl2_w[C2_DACKINV] ? dack_s : ~dack_s;
    assign rd_strobe = ~cs_s & ((dma_en & ctl2_w[C2_DACKRD]) ? dack_act : ~rd_s);
    assign wr_strobe = ~cs_s & ~wr_s;
    assign use_wide  = wide_bus & ~dma_en;

    // next-state logic
    always_comb begin
        state_d     = state_q;
        cnt_d       = cnt_q;
        acc_start   = 1'b0;
        drive_start = 1'b0;
        drive_end   = 1'b0;
        wr_go       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_strobe) begin
                    state_d   = ST_ACCESS;
                    acc_start = 1'b1;
                    cnt_d     = (addr == RA_DATA && use_wide) ? CW'(ACC16 - 1) : CW'(ACC8 - 1);
                end else if (wr_strobe) begin
                    state_d = ST_WR_HOLD;
                    wr_go   = 1'b1;
                end
            end
            ST_ACCESS: begin
                if (cnt_q == '0) begin
                    state_d     = ST_DRIVE;
                    drive_start = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_DRIVE: begin
                if (!rd_strobe) begin
                    state_d   = ST_RECOVER;
                    drive_end = 1'b1;
                    cnt_d     = (dma_en && addr_q == RA_DATA) ? CW'(DMA_REC - 1) : CW'(REC - 1);
                end
            end
            ST_WR_HOLD: begin
                if (!wr_strobe) begin
                    state_d = ST_RECOVER;
                    cnt_d   = CW'(REC - 1);
                end
            end
            ST_RECOVER: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // read data selection
    always_comb begin
        case (addr_q)
            RA_DATA:  rdata_d = {wide_q ? pk_hi : 8'h00, pk_lo};
            RA_STAT:  rdata_d = {8'h00, stat_in};
            RA_BLKNO: rdata_d = {8'h00, blkno_in};
            default:  rdata_d = 16'h0000;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wide_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (acc_start) begin
                addr_q <= addr;
                wide_q <= use_wide;
            end
            if (drive_start) rdata_q <= rdata_d;
        end
    end

    // outputs
    always_comb begin
        dout_oe_lo = (state_q == ST_DRIVE);
        dout_oe_hi = (state_q == ST_DRIVE) && wide_q;
        dout       = (state_q == ST_DRIVE) ? rdata_q : 16'h0000;
        rdy        = ctl2_w[C2_RDYALT] ? (state_q != ST_DRIVE) : (state_q != ST_ACCESS);
        dreq_act   = dma_en && (state_q == ST_IDLE) && pk_avail;
        dreq       = ctl2_w[C2_DREQINV] ? dreq_act : ~dreq_act;
    end

    // R4
    hi_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe_hi |-> (dout_oe_lo && wide_bus && !cfg_ctl2[C2_DMA]));

    // R12
    recover_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dout_oe_lo) |=> !dout_oe_lo);

    // R9
    dreq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ctl2[C2_DREQINV] ? dreq : !dreq) |-> !dout_oe_lo);

    // R5
    rdy_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe_lo && !cfg_ctl2[C2_RDYALT]) |-> rdy);

    // R6
    rdy_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe_lo && cfg_ctl2[C2_RDYALT]) |-> !rdy);

endmodule

// File: tb/host_port_dma_bench.sv
module host_port_dma_bench;

    localparam int NB     = 22;
    localparam int ACC8_C = 4;
    localparam int ACC16_C = 8;
    localparam int REC_C  = 6;
    localparam int DREC_C = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, dack = 1'b1;
    logic [3:0]  addr = '0;
    logic        wide_bus = 1'b0;
    logic [7:0]  din = '0;
    logic [15:0] dout;
    logic        oe_lo, oe_hi, rdy, dreq;
    logic [7:0]  stat_in = 8'hA5, blkno_in = 8'h3C;
    logic        pkt_we = 1'b0;
    logic [4:0]  pkt_widx = '0;
    logic [7:0]  pkt_wdata = '0;
    logic        pkt_release = 1'b0;
    logic [7:0]  c_bic, c_bsync, c_fsync, c_ctl1, c_ctl2, c_crc;
    logic        crc_strobe;

    int checks = 0;
    int fails  = 0;
    int crc_cnt = 0;
    bit done = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        oe_d = 1'b0;

    always #2.5 clk = ~clk;

    host_port_dma u_host_port_dma (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .dack(dack),
        .addr(addr), .wide_bus(wide_bus), .din(din), .dout(dout),
        .dout_oe_lo(oe_lo), .dout_oe_hi(oe_hi), .rdy(rdy), .dreq(dreq),
        .stat_in(stat_in), .blkno_in(blkno_in), .pkt_we(pkt_we), .pkt_widx(pkt_widx),
        .pkt_wdata(pkt_wdata), .pkt_release(pkt_release),
        .cfg_bic(c_bic), .cfg_bsync(c_bsync), .cfg_fsync(c_fsync), .cfg_ctl1(c_ctl1),
        .cfg_ctl2(c_ctl2), .crc_byte(c_crc), .crc_strobe(crc_strobe)
    );

    function automatic logic [7:0] pk(input int i);
        return 8'(16 + 7 * i);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // scoreboard monitor: compares each new data phase with the queued expectation
    always @(negedge clk) begin
        if (oe_lo && !oe_d) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "unexpected data phase", dout, 16'h0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(dout === e, t, dout, e);
            end
        end
        oe_d = oe_lo;
        if (crc_strobe) crc_cnt++;
    end

    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; cs_n = 1'b0; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        repeat (REC_C + 6) @(negedge clk);
    endtask

    task automatic do_read(input logic [3:0] a, input logic [15:0] e, input string tag,
                           input bit via_dack, input logic dack_on,
                           output int lowcnt, output bit hi_seen);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        addr = a; cs_n = 1'b0;
        if (via_dack) dack = dack_on; else rd_n = 1'b0;
        lowcnt = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!rdy) lowcnt++;
            if (oe_lo) break;
        end
        hi_seen = oe_hi;
        repeat (2) @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        if (via_dack) dack = ~dack_on;
        repeat (DREC_C + 6) @(negedge clk);
    endtask

    task automatic load_packet;
        for (int i = 0; i < NB; i++) begin
            @(negedge clk);
            pkt_we = 1'b1; pkt_widx = 5'(i); pkt_wdata = pk(i);
        end
        @(negedge clk);
        pkt_we = 1'b0;
        pkt_release = 1'b1;
        @(negedge clk);
        pkt_release = 1'b0;
    endtask

    task automatic release_pkt;
        @(negedge clk);
        pkt_release = 1'b1;
        @(negedge clk);
        pkt_release = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int lc;
        bit hs;
        int cnt;
        logic [7:0] s_bic, s_bs, s_fs, s_c1, s_c2, s_crc;
        int crc_before;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R11 reset state
        chk(rdy === 1'b1 && dreq === 1'b1, "R11 rdy/dreq idle high", {14'h0, rdy, dreq}, 16'h3);
        chk(oe_lo === 1'b0 && oe_hi === 1'b0, "R11 enables off", {14'h0, oe_lo, oe_hi}, 16'h0);
        chk({c_bic, c_bsync, c_fsync, c_ctl1, c_ctl2, c_crc} === 48'h0, "R11 cfg zero",
            {c_bic, c_ctl2}, 16'h0);

        // R1 write map
        do_write(4'h1, 8'h11);
        do_write(4'h2, 8'h22);
        do_write(4'h3, 8'h33);
        do_write(4'h4, 8'h44);
        do_write(4'h5, 8'h40);
        do_write(4'h6, 8'h66);
        chk(c_bic === 8'h11 && c_bsync === 8'h22, "R1 regs 1-2", {c_bic, c_bsync}, 16'h1122);
        chk(c_fsync === 8'h33 && c_ctl1 === 8'h44, "R1 regs 3-4", {c_fsync, c_ctl1}, 16'h3344);
        chk(c_ctl2 === 8'h40 && c_crc === 8'h66, "R1 regs 5-6", {c_ctl2, c_crc}, 16'h4066);
        chk(crc_cnt == 1, "R1 crc strobe one cycle", 16'(crc_cnt), 16'd1);

        // R2 prohibited writes
        s_bic = c_bic; s_bs = c_bsync; s_fs = c_fsync; s_c1 = c_ctl1; s_c2 = c_ctl2; s_crc = c_crc;
        crc_before = crc_cnt;
        do_write(4'h0, 8'hEE);
        do_write(4'h7, 8'hEE);
        do_write(4'hF, 8'hEE);
        chk({c_bic, c_bsync, c_fsync} === {s_bic, s_bs, s_fs}, "R2 regs 1-3 unchanged",
            {c_bic, c_fsync}, {s_bic, s_fs});
        chk({c_ctl1, c_ctl2, c_crc} === {s_c1, s_c2, s_crc}, "R2 regs 4-6 unchanged",
            {c_ctl1, c_ctl2}, {s_c1, s_c2});
        chk(crc_cnt == crc_before, "R2 no crc strobe", 16'(crc_cnt), 16'(crc_before));

        // R3 register reads, narrow bus
        do_read(4'h1, 16'h00A5, "R3 status read", 1'b0, 1'b0, lc, hs);
        chk(hs == 1'b0, "R4 narrow high byte off", {15'h0, hs}, 16'h0);
        do_read(4'h2, 16'h003C, "R3 block number read", 1'b0, 1'b0, lc, hs);
        do_read(4'h3, 16'h0000, "R3 reserved 3 zero", 1'b0, 1'b0, lc, hs);
        do_read(4'h9, 16'h0000, "R3 reserved 9 zero", 1'b0, 1'b0, lc, hs);

        // R7 narrow packet reads, R5 default ready timing
        load_packet();
        for (int i = 0; i < 3; i++) begin
            do_read(4'h0, {8'h00, pk(i)}, "R7 narrow packet byte", 1'b0, 1'b0, lc, hs);
            chk(lc == ACC8_C, "R5 rdy low cycles narrow", 16'(lc), 16'(ACC8_C));
        end

        // R8 / R4 wide packet read
        wide_bus = 1'b1;
        do_read(4'h0, {pk(4), pk(3)}, "R7 wide packet pair", 1'b0, 1'b0, lc, hs);
        chk(lc == ACC16_C, "R8 wide data access length", 16'(lc), 16'(ACC16_C));
        chk(hs == 1'b1, "R4 wide high byte on", {15'h0, hs}, 16'h1);
        do_read(4'h1, 16'h00A5, "R3 wide status read", 1'b0, 1'b0, lc, hs);
        chk(lc == ACC8_C, "R8 register read keeps short wait", 16'(lc), 16'(ACC8_C));

        // R6 alternative ready style
        do_write(4'h5, 8'h08);
        do_read(4'h0, {pk(6), pk(5)}, "R7 wide pair alt style", 1'b0, 1'b0, lc, hs);
        chk(lc == 1, "R6 rdy low only in data phase", 16'(lc), 16'd1);
        chk(rdy === 1'b1, "R6 rdy high after release", {15'h0, rdy}, 16'h1);

        // R7 walk to end, saturation, release
        for (int p = 7; p < 21; p += 2)
            do_read(4'h0, {pk(p + 1), pk(p)}, "R7 wide walk", 1'b0, 1'b0, lc, hs);
        do_read(4'h0, {8'h00, pk(21)}, "R7 last byte high zero", 1'b0, 1'b0, lc, hs);
        do_read(4'h0, 16'h0000, "R7 beyond end zero", 1'b0, 1'b0, lc, hs);
        release_pkt();
        do_read(4'h0, {pk(1), pk(0)}, "R7 pointer cleared by release", 1'b0, 1'b0, lc, hs);

        // R12 recovery gap, default style narrow, pointer at 2
        do_write(4'h5, 8'h00);
        wide_bus = 1'b0;
        exp_q.push_back({8'h00, pk(2)}); tag_q.push_back("R12 first read");
        exp_q.push_back({8'h00, pk(3)}); tag_q.push_back("R12 second read");
        @(negedge clk);
        addr = 4'h0; cs_n = 1'b0; rd_n = 1'b0;
        for (int i = 0; i < 100 && !oe_lo; i++) @(negedge clk);
        @(negedge clk); rd_n = 1'b1;
        @(negedge clk); rd_n = 1'b0;
        for (int i = 0; i < 100 && oe_lo; i++) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            cnt++;
            if (!rdy) break;
        end
        chk(cnt == REC_C + 1, "R12 recovery before next access", 16'(cnt), 16'(REC_C + 1));
        for (int i = 0; i < 100 && !oe_lo; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        repeat (REC_C + 6) @(negedge clk);

        // R9 DMA mode through rd_n, strap high but forced narrow
        wide_bus = 1'b1;
        do_write(4'h5, 8'h01);
        release_pkt();
        repeat (3) @(negedge clk);
        chk(dreq === 1'b0, "R9 request active low", {15'h0, dreq}, 16'h0);
        exp_q.push_back({8'h00, pk(0)}); tag_q.push_back("R9 dma byte 0");
        @(negedge clk);
        addr = 4'h0; cs_n = 1'b0; rd_n = 1'b0;
        for (int i = 0; i < 100 && !oe_lo; i++) @(negedge clk);
        chk(oe_hi === 1'b0, "R9 dma forces 8-bit", {15'h0, oe_hi}, 16'h0);
        chk(dreq === 1'b1, "R9 request off during access", {15'h0, dreq}, 16'h1);
        repeat (2) @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        for (int i = 0; i < 100 && oe_lo; i++) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 100 && dreq; i++) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == DREC_C, "R12 dma request gap", 16'(cnt), 16'(DREC_C));

        // R10 acknowledge replaces read strobe
        do_write(4'h5, 8'h03);
        @(negedge clk);
        addr = 4'h0; cs_n = 1'b0; rd_n = 1'b0;
        repeat (12) @(negedge clk);
        chk(oe_lo === 1'b0 && rdy === 1'b1, "R10 rd ignored in ack mode", {14'h0, oe_lo, rdy}, 16'h1);
        cs_n = 1'b1; rd_n = 1'b1;
        repeat (REC_C + 6) @(negedge clk);
        do_read(4'h0, {8'h00, pk(1)}, "R10 ack low strobe", 1'b1, 1'b0, lc, hs);

        // R10 inverted polarities
        do_write(4'h5, 8'h33);
        dack = 1'b0;
        repeat (3) @(negedge clk);
        chk(dreq === 1'b1, "R10 request active high", {15'h0, dreq}, 16'h1);
        do_read(4'h0, {8'h00, pk(2)}, "R10 ack high strobe", 1'b1, 1'b1, lc, hs);
        for (int i = 3; i < NB; i++)
            do_read(4'h0, {8'h00, pk(i)}, "R9 dma drain", 1'b1, 1'b1, lc, hs);
        chk(dreq === 1'b0, "R9 no request when empty", {15'h0, dreq}, 16'h0);

        chk(exp_q.size() == 0, "scoreboard drained", 16'(exp_q.size()), 16'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule